// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Hundredths

This block is a synchronous real-time clock core. It holds the time of day and the calendar in packed BCD across eight 8-bit registers: hundredths, seconds, minutes, hours, day of week, date, month and two-digit year. A single-cycle enable pulse at 100 Hz advances the chain. Each field carries into the next, and month ends and leap years are handled automatically. Hours can run in 24-hour form or in 12-hour form with a PM flag.

Software, or a serial front end outside this block, writes all eight registers at once through a parallel load. It reads them back at any time as one 64-bit word. Two control bits sit in the day-of-week register. One stops the oscillator, which freezes all counting. The other decides whether an external active-low reset line may request an abort of the surrounding transfer logic.

Top module: `bcd_rtc_core`

## Requirements
- R1: After the synchronous reset, `rd_data` reads 64'h00_01_01_31_00_00_00_00. That is year 00, month 01, date 01, day register 0x31 (oscillator stopped, reset ignored, day 1) and time 00:00:00.00 in 24-hour mode. `xfer_abort` reads 0.
- R2: Register i sits at `rd_data[8*i+7:8*i]`, with 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. Each tick advances hundredths 00..99, seconds 00..59 and minutes 00..59 in BCD, and each wrap carries into the next field. Without a tick or a load, the registers hold.
- R3: In 24-hour mode (hours bit 7 = 0), bit 5 is the tens bit for 20..23. The step from 23:59:59.99 goes to 00:00:00.00 and advances the day.
- R4: In 12-hour mode (hours bit 7 = 1), bit 5 is PM when 1 and the hour is BCD 01..12 in bits 4:0. The step from 11 goes to 12 and toggles PM. The step from 12 goes to 01. Only 11 PM to 12 AM advances the day.
- R5: Day of week (day register bits 2:0) counts 1..7 and wraps to 1 on each day advance.
- R6: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. February ends on 29 when the BCD year is divisible by 4 (00 included) and on 28 otherwise.
- R7: When the date wraps, the month advances. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R8: While day register bit 5 is 1, ticks change nothing.
- R9: A load writes all eight registers in one cycle and wins over a tick in the same cycle. The next tick counts on from the loaded value.
- R10: Unused bits read 0 whatever was loaded. With `rd_data` bits set to 1 only in mask 64'hFF_1F_3F_37_BF_7F_7F_FF, a load of all ones reads back as that mask.
- R11: One cycle after `ext_reset_n` is low while day register bit 4 is 0, `xfer_abort` is 1. It is 0 when `ext_reset_n` is high or bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle 100 Hz advance pulse |
| load_en | input | 1 | Parallel load of all eight registers |
| load_data | input | 64 | Load value, register i in bits 8*i+7:8*i |
| ext_reset_n | input | 1 | External active-low reset request |
| rd_data | output | 64 | Current register contents, same packing |
| xfer_abort | output | 1 | Registered abort request for the transfer logic |

## Verification
The cycle-by-cycle assertions check these rules:
- registers freeze while the oscillator bit is set, or when neither a tick nor a load arrives;
- a load lands masked in the following cycle;
- unused bits stay zero;
- the 24-hour midnight rollover clears the time fields;
- the abort output follows the reset line and the ignore bit.

Only the bench's loaded scenarios show the calendar arithmetic. These cover the 12-hour PM sequence, the day-of-week wrap, the month lengths and leap-year cases including year 00, and the year-end rollover. A hundred-tick run shows the hundredths carrying into seconds.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int BUS_W    = REG_W * NUM_REGS;

  // bits that can hold a 1 in each register (others read zero)
  localparam logic [BUS_W-1:0] LIVE_MASK =
    {8'hFF, 8'h1F, 8'h3F, 8'h37, 8'hBF, 8'h7F, 8'h7F, 8'hFF};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] q,
  output logic         wrap
);
  logic [7:0] q8, hi8;
  assign q8   = 8'(q);
  assign hi8  = 8'(hi);
  assign wrap = inc & (q8 >= hi8);

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (ld)  q <= ld_val;
    else if (inc) q <= wrap ? lo : W'(rtc_pkg::bcd_inc(q8));
  end
endmodule

// File: rtl/rtc_hour_counter.sv
module rtc_hour_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic       ld_mode12,
  input  logic [5:0] ld_hv,
  input  logic       inc,
  output logic [7:0] q,
  output logic       day_carry
);
  logic       mode12;
  logic [5:0] hv, hv_next;
  logic       wrap_cond;
  logic [7:0] h24, h12;

  assign h24 = {2'b00, hv};
  assign h12 = {3'b000, hv[4:0]};

  always_comb begin
    wrap_cond = 1'b0;
    if (!mode12) begin
      if (h24 >= 8'h23) begin
        hv_next   = 6'h00;
        wrap_cond = 1'b1;
      end else begin
        hv_next = rtc_pkg::bcd_inc(h24)[5:0];
      end
    end else if (h12 >= 8'h12) begin
      hv_next = {hv[5], 5'h01};
    end else if (h12 == 8'h11) begin
      hv_next   = {~hv[5], 5'h12};
      wrap_cond = hv[5];
    end else begin
      hv_next = {hv[5], rtc_pkg::bcd_inc(h12)[4:0]};
    end
  end

  assign day_carry = inc & wrap_cond;
  assign q = {mode12, 1'b0, hv};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode12 <= 1'b0;
      hv     <= 6'h00;
    end else if (ld) begin
      mode12 <= ld_mode12;
      hv     <= ld_hv;
    end else if (inc) begin
      hv <= hv_next;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter logic [7:0] INIT_YEAR  = 8'h00,
  parameter logic [4:0] INIT_MONTH = 5'h01,
  parameter logic [5:0] INIT_DATE  = 6'h01,
  parameter logic [2:0] INIT_DOW   = 3'd1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [2:0] ld_dow,
  input  logic [5:0] ld_date,
  input  logic [4:0] ld_mon,
  input  logic [7:0] ld_yr,
  input  logic       day_inc,
  output logic [2:0] dow,
  output logic [5:0] date,
  output logic [4:0] mon,
  output logic [7:0] yr
);
  logic       unused_dow_wrap, unused_yr_wrap;
  logic       date_wrap, mon_wrap;
  logic [7:0] month_end;

  assign month_end = rtc_pkg::last_day(8'(mon), yr);

  rtc_bcd_counter #(.W(3), .RST_VAL(INIT_DOW)) u_dow (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_dow), .inc(day_inc),
    .lo(3'd1), .hi(3'd7), .q(dow), .wrap(unused_dow_wrap));

  rtc_bcd_counter #(.W(6), .RST_VAL(INIT_DATE)) u_date (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_date), .inc(day_inc),
    .lo(6'h01), .hi(month_end[5:0]), .q(date), .wrap(date_wrap));

  rtc_bcd_counter #(.W(5), .RST_VAL(INIT_MONTH)) u_mon (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_mon), .inc(date_wrap),
    .lo(5'h01), .hi(5'h12), .q(mon), .wrap(mon_wrap));

  rtc_bcd_counter #(.W(8), .RST_VAL(INIT_YEAR)) u_yr (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_yr), .inc(mon_wrap),
    .lo(8'h00), .hi(8'h99), .q(yr), .wrap(unused_yr_wrap));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter logic [7:0] INIT_YEAR  = 8'h00,
  parameter logic [4:0] INIT_MONTH = 5'h01,
  parameter logic [5:0] INIT_DATE  = 6'h01,
  parameter logic [2:0] INIT_DOW   = 3'd1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_en,
  input  logic                       load_en,
  input  logic [rtc_pkg::BUS_W-1:0]  load_data,
  input  logic                       ext_reset_n,
  output logic [rtc_pkg::BUS_W-1:0]  rd_data,
  output logic                       xfer_abort
);
  import rtc_pkg::*;

  localparam int N_TIME = 3;                 // hundredths, seconds, minutes
  localparam logic [7:0] TIME_HI [N_TIME] = '{8'h99, 8'h59, 8'h59};

  logic osc_off, rst_ignore, run;
  logic [7:0] tq [N_TIME];
  logic       tinc [N_TIME+1];
  logic [7:0] hour_q;
  logic       day_inc;
  logic [2:0] dow;
  logic [5:0] date;
  logic [4:0] mon;
  logic [7:0] yr;
  logic       unused_ld_bits;

  assign unused_ld_bits = ^{load_data[15], load_data[23], load_data[30], load_data[35],
                            load_data[39:38], load_data[47:46], load_data[55:53]};

  assign run     = tick_en & ~osc_off & ~load_en;
  assign tinc[0] = run;

  for (genvar i = 0; i < N_TIME; i++) begin : g_time
    localparam int CW = (i == 0) ? REG_W : REG_W - 1;
    logic [CW-1:0] cnt_q;
    rtc_bcd_counter #(.W(CW), .RST_VAL('0)) u_cnt (
      .clk(clk), .rst(rst), .ld(load_en), .ld_val(load_data[REG_W*i +: CW]),
      .inc(tinc[i]), .lo('0), .hi(CW'(TIME_HI[i])), .q(cnt_q), .wrap(tinc[i+1]));
    assign tq[i] = 8'(cnt_q);
  end

  rtc_hour_counter u_hour (
    .clk(clk), .rst(rst), .ld(load_en), .ld_mode12(load_data[31]),
    .ld_hv(load_data[29:24]), .inc(tinc[N_TIME]), .q(hour_q), .day_carry(day_inc));

  rtc_calendar #(
    .INIT_YEAR(INIT_YEAR), .INIT_MONTH(INIT_MONTH),
    .INIT_DATE(INIT_DATE), .INIT_DOW(INIT_DOW)
  ) u_cal (
    .clk(clk), .rst(rst), .ld(load_en),
    .ld_dow(load_data[34:32]), .ld_date(load_data[45:40]),
    .ld_mon(load_data[52:48]), .ld_yr(load_data[63:56]),
    .day_inc(day_inc), .dow(dow), .date(date), .mon(mon), .yr(yr));

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_off    <= 1'b1;
      rst_ignore <= 1'b1;
      xfer_abort <= 1'b0;
    end else begin
      xfer_abort <= ~ext_reset_n & ~rst_ignore;
      if (load_en) begin
        osc_off    <= load_data[37];
        rst_ignore <= load_data[36];
      end
    end
  end

  assign rd_data = {yr, 3'b000, mon, 2'b00, date,
                    2'b00, osc_off, rst_ignore, 1'b0, dow,
                    hour_q, tq[2], tq[1], tq[0]};
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker (
  input logic        clk,
  input logic        rst,
  input logic        tick_en,
  input logic        load_en,
  input logic [63:0] load_data,
  input logic        ext_reset_n,
  input logic [63:0] rd_data,
  input logic        xfer_abort
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load_en) |=> $stable(rd_data));

  assert_midnight_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !load_en && !rd_data[37] && rd_data[31:0] == 32'h23595999)
    |=> (rd_data[31:0] == 32'h0));

  assert_osc_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_data[37] && !load_en) |=> $stable(rd_data));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (rd_data == ($past(load_data) & rtc_pkg::LIVE_MASK)));

  assert_zero_bits_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~rtc_pkg::LIVE_MASK) == 64'h0);

  assert_abort_set_R11: assert property (@(posedge clk) disable iff (rst)
    (!ext_reset_n && !rd_data[36]) |=> xfer_abort);

  assert_abort_clr_R11: assert property (@(posedge clk) disable iff (rst)
    (ext_reset_n || rd_data[36]) |=> !xfer_abort);
endmodule

bind bcd_rtc_core rtc_core_checker u_chk (.*);

// File: tb/sim_bcd_rtc_core.sv
`timescale 1ns/1ps
module sim_bcd_rtc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        load_en = 1'b0;
  logic [63:0] load_data = 64'h0;
  logic        ext_reset_n = 1'b1;
  logic [63:0] rd_data;
  logic        xfer_abort;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bcd_rtc_core u0 (.clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
    .load_data(load_data), .ext_reset_n(ext_reset_n), .rd_data(rd_data),
    .xfer_abort(xfer_abort));

  // {year, month, date, day, hours, minutes, seconds, hundredths}
  localparam int NV = 20;
  localparam logic [63:0] V_IN [NV] = '{
    64'h24_03_15_13_10_20_30_45, // R2 plain step
    64'h24_03_15_13_08_59_59_99, // R2 carry into hours
    64'h24_03_15_13_23_59_59_99, // R3 midnight
    64'h24_03_15_13_91_59_59_99, // R4 11 AM -> 12 PM
    64'h24_03_15_13_B2_59_59_99, // R4 12 PM -> 1 PM
    64'h24_03_15_13_B1_59_59_99, // R4 11 PM -> 12 AM, day advances
    64'h24_03_15_13_92_59_59_99, // R4 12 AM -> 1 AM
    64'h24_03_15_17_23_59_59_99, // R5 day 7 -> 1
    64'h24_04_30_13_23_59_59_99, // R6 30-day month
    64'h24_11_30_13_23_59_59_99, // R6 30-day month
    64'h24_01_30_13_23_59_59_99, // R6 31-day month keeps going
    64'h24_01_31_13_23_59_59_99, // R6 31-day month ends
    64'h23_02_28_13_23_59_59_99, // R6 common year
    64'h24_02_28_13_23_59_59_99, // R6 leap year
    64'h24_02_29_13_23_59_59_99, // R6 leap February ends
    64'h00_02_28_13_23_59_59_99, // R6 year 00 is leap
    64'h12_02_28_13_23_59_59_99, // R6 odd tens leap
    64'h10_02_28_13_23_59_59_99, // R6 odd tens common
    64'h99_12_31_13_23_59_59_99, // R7 year end
    64'h24_12_31_13_23_59_59_99  // R7 month 12 wraps, year advances
  };
  localparam logic [63:0] V_EXP [NV] = '{
    64'h24_03_15_13_10_20_30_46,
    64'h24_03_15_13_09_00_00_00,
    64'h24_03_16_14_00_00_00_00,
    64'h24_03_15_13_B2_00_00_00,
    64'h24_03_15_13_A1_00_00_00,
    64'h24_03_16_14_92_00_00_00,
    64'h24_03_15_13_81_00_00_00,
    64'h24_03_16_11_00_00_00_00,
    64'h24_05_01_14_00_00_00_00,
    64'h24_12_01_14_00_00_00_00,
    64'h24_01_31_14_00_00_00_00,
    64'h24_02_01_14_00_00_00_00,
    64'h23_03_01_14_00_00_00_00,
    64'h24_02_29_14_00_00_00_00,
    64'h24_03_01_14_00_00_00_00,
    64'h00_02_29_14_00_00_00_00,
    64'h12_02_29_14_00_00_00_00,
    64'h10_03_01_14_00_00_00_00,
    64'h00_01_01_14_00_00_00_00,
    64'h25_01_01_14_00_00_00_00
  };
  localparam int V_REQ [NV] = '{2, 2, 3, 4, 4, 4, 4, 5, 6, 6, 6, 6, 6, 6, 6, 6, 6, 6, 7, 7};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] v, input logic with_tick);
    @(negedge clk);
    load_en = 1'b1; load_data = v; tick_en = with_tick;
    @(negedge clk);
    load_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset registers", rd_data, 64'h00_01_01_31_00_00_00_00);
    check("R1 reset abort", {63'h0, xfer_abort}, 64'h0);
    // R8 oscillator stopped after reset: ticks have no effect
    do_ticks(5);
    check("R8 ticks while stopped", rd_data, 64'h00_01_01_31_00_00_00_00);

    for (int i = 0; i < NV; i++) begin
      do_load(V_IN[i], 1'b0);
      do_ticks(1);
      checks++;
      if (rd_data !== V_EXP[i]) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", V_REQ[i], i, rd_data, V_EXP[i]);
      end
    end

    // R2 hundred ticks carry one second; no tick holds
    do_load(64'h24_03_15_13_10_20_30_00, 1'b0);
    do_ticks(100);
    check("R2 hundred ticks", rd_data, 64'h24_03_15_13_10_20_31_00);
    repeat (10) @(negedge clk);
    check("R2 hold without tick", rd_data, 64'h24_03_15_13_10_20_31_00);

    // R9 load wins over a tick in the same cycle, then counts from it
    do_load(64'h24_03_15_13_10_20_30_45, 1'b1);
    check("R9 load beats tick", rd_data, 64'h24_03_15_13_10_20_30_45);
    do_ticks(1);
    check("R9 counts from loaded", rd_data, 64'h24_03_15_13_10_20_30_46);

    // R8 stop bit set by load
    do_load(64'h24_03_15_33_10_20_30_45, 1'b0);
    do_ticks(3);
    check("R8 stopped by load", rd_data, 64'h24_03_15_33_10_20_30_45);

    // R11 abort follows ext reset when not ignored
    do_load(64'h24_03_15_01_10_20_30_00, 1'b0);
    ext_reset_n = 1'b0;
    @(negedge clk);
    check("R11 abort raised", {63'h0, xfer_abort}, 64'h1);
    do_load(64'h24_03_15_11_10_20_30_00, 1'b0);
    @(negedge clk);
    check("R11 abort ignored", {63'h0, xfer_abort}, 64'h0);
    ext_reset_n = 1'b1;
    do_load(64'h24_03_15_01_10_20_30_00, 1'b0);
    @(negedge clk);
    check("R11 abort idle high", {63'h0, xfer_abort}, 64'h0);

    // R10 unused bits read zero
    do_load(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    check("R10 zero bits", rd_data, 64'hFF_1F_3F_37_BF_7F_7F_FF);

    // R1 reset again restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 second reset", rd_data, 64'h00_01_01_31_00_00_00_00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule